// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus-side engine of a 16-bit processor that reaches a 20-bit address space. A caller hands it one transfer: a 16-bit segment base, a 16-bit offset, a selector naming which segment register the base came from, a direction, a memory-or-I/O space flag, a word-or-byte size flag and, for writes, the data. The block adds the segment (moved up by four bit positions) to the offset. The sum wraps within 20 bits. It then runs a bus cycle of four clock states on shared pins.

The low 16 bus lines carry the low address bits in the first state and carry data after that. The top four lines and the high-byte-enable line carry the rest of the address in the first state and carry status after that. An address latch pulse tells external latches when to capture the address. Active-low read, write and transceiver-enable strobes frame the data phase, and a direction line steers the transceiver. A ready input stretches the data phase with wait states. Read data is captured and returned together with a one-cycle done pulse. A request is taken only while the block reports idle.

Top module: `busseq_unit`

## Requirements
- R1: In the first state (T1), `ad_out` equals bits 15..0 and `as_out` equals bits 19..16 of ((segment × 16) + offset) mod 2^20.
- R2: `ale` is high for exactly one cycle, T1, which is the cycle after a request is accepted. It is low in all other cycles.
- R3: `rd_n` (reads) or `wr_n` (writes) and `den_n` are low from T2 through T3 and any wait states. All three are high in T1, in T4 and while idle. `rd_n` and `wr_n` are never low together.
- R4: `ready_in` is sampled at the end of T3 and at the end of each wait state. Each low sample adds one wait state before T4.
- R5: For a read, the value on `ad_in` at the clock edge where `ready_in` is sampled high appears on `rdata` during T4.
- R6: `done` is high only in T4. The block is idle in the cycle after T4.
- R7: From T1 to T4, `io_m` equals the I/O flag (1 = I/O, 0 = memory) and `dt_r` equals the write flag (0 = read, 1 = write). Both hold steady for the whole cycle.
- R8: `ad_oe` is high in T1. From T2 to T4 it is high for writes, with `ad_out` equal to the write data, and low for reads, so the bus floats.
- R9: From T2 to T4, `as_out` carries the status nibble {S6,S5,S4,S3} = {0,0,segsel[1],segsel[0]}, and `bhe_n` carries S7 = 0.
- R10: In T1, `bhe_n` is low when the access is a word or the physical address is odd. It is high for an even-address byte access.
- R11: `req_valid` has no effect while `cyc_idle` is low. The cycle in flight keeps its address, data and status, and no new cycle starts afterwards.
- R12: After reset the block is idle. All strobes are high, `ale`, `ad_oe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_seg | input | 16 | Segment base value |
| req_off | input | 16 | Offset within the segment |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_segsel | input | 2 | Code of the segment register in use |
| req_wdata | input | 16 | Write data |
| ready_in | input | 1 | Slave ready; low inserts wait states |
| ad_in | input | 16 | Data returned on the shared bus |
| cyc_idle | output | 1 | High when a request can be taken |
| ad_out | output | 16 | Shared address/data lines, output value |
| ad_oe | output | 1 | Output enable for `ad_out` |
| as_out | output | 4 | Shared upper address / status lines |
| bhe_n | output | 1 | High-byte enable (T1) / status S7 |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | Space indicator, 1 = I/O |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 0 = receive |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet in one cycle: the end of the running transfer, with `done` high in T4, and the arrival of the next request. The sweep holds `req_valid` high with different fields from T1 to the end of T4 of every transfer. The block must ignore that request, finish the current cycle with unchanged address, data and status, and be back in idle without a latch pulse in the cycle after T4. Wait counts from zero to two are crossed with each direction, each space and each size, so the ready sample in T3 or in a wait state also falls together with read capture.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_t;

  typedef struct packed {
    logic       write;
    logic       io;
    logic       word;
    logic [1:0] segsel;
  } cyc_attr_t;

endpackage

// File: rtl/busseq_addr.sv
module busseq_addr #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);

  logic [ADDR_W-1:0] base_ext;
  logic [ADDR_W-1:0] off_ext;

  assign base_ext = {seg, {SHIFT{1'b0}}};

  generate
    if (OFF_W < ADDR_W) begin : g_off_pad
      assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, off};
    end else begin : g_off_trim
      assign off_ext = off[ADDR_W-1:0];
    end
  endgenerate

  // carry out of the top bit is dropped: sum wraps within the address space
  assign phys = base_ext + off_ext;

endmodule

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ready_in,
  output bus_state_t state,
  output logic       cap_en,
  output logic       done,
  output logic       idle
);

  bus_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ready_in ? ST_T4 : ST_TW;
      ST_TW:   state_d = ready_in ? ST_T4 : ST_TW;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state  = state_q;
  assign cap_en = ((state_q == ST_T3) || (state_q == ST_TW)) && ready_in;
  assign done   = (state_q == ST_T4);
  assign idle   = (state_q == ST_IDLE);

  // R4: completion only follows a high ready sample
  p_done_after_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ready_in));

  // R6: completion is a single cycle and is followed by idle
  p_done_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idle && !done));

endmodule

// File: rtl/busseq_pins.sv
module busseq_pins
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int TOP_W = ADDR_W - DATA_W
) (
  input  bus_state_t        state,
  input  cyc_attr_t         attr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [TOP_W-1:0]  as_out,
  output logic              bhe_n,
  output logic              ale,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dt_r
);

  logic addr_ph, data_ph, strobe_ph, active;
  logic [TOP_W-1:0] status;

  always_comb begin
    addr_ph   = (state == ST_T1);
    strobe_ph = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
    data_ph   = strobe_ph || (state == ST_T4);
    active    = (state != ST_IDLE);

    status      = '0;
    status[1:0] = attr.segsel;

    ale    = addr_ph;
    ad_oe  = addr_ph || (data_ph && attr.write);
    if (addr_ph)                     ad_out = addr[DATA_W-1:0];
    else if (data_ph && attr.write)  ad_out = wdata;
    else                             ad_out = '0;

    if (addr_ph)     as_out = addr[ADDR_W-1:DATA_W];
    else if (active) as_out = status;
    else             as_out = '0;

    if (addr_ph)     bhe_n = !(attr.word || addr[0]);
    else if (active) bhe_n = 1'b0;
    else             bhe_n = 1'b1;

    rd_n  = !(strobe_ph && !attr.write);
    wr_n  = !(strobe_ph &&  attr.write);
    den_n = !strobe_ph;
    io_m  = active && attr.io;
    dt_r  = active ? attr.write : 1'b1;
  end

endmodule

// File: rtl/busseq_unit.sv
module busseq_unit
  import busseq_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int TOP_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_word,
  input  logic [1:0]        req_segsel,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic              cyc_idle,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [TOP_W-1:0]  as_out,
  output logic              bhe_n,
  output logic              ale,
  output logic              io_m,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dt_r,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  bus_state_t        state;
  logic              start, cap_en, idle;
  logic [ADDR_W-1:0] phys;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  cyc_attr_t         attr_q, attr_d;

  assign start  = req_valid && idle;
  assign attr_d = '{write: req_write, io: req_io, word: req_word, segsel: req_segsel};

  busseq_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_addr (
    .seg  (req_seg),
    .off  (req_off),
    .phys (phys)
  );

  busseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ready_in (ready_in),
    .state    (state),
    .cap_en   (cap_en),
    .done     (done),
    .idle     (idle)
  );

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      attr_q  <= '0;
    end else if (start) begin
      addr_q  <= phys;
      wdata_q <= req_wdata;
      attr_q  <= attr_d;
    end
  end

  // read data capture, enabled on the last ready sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

  busseq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state  (state),
    .attr   (attr_q),
    .addr   (addr_q),
    .wdata  (wdata_q),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .as_out (as_out),
    .bhe_n  (bhe_n),
    .ale    (ale),
    .io_m   (io_m),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .den_n  (den_n),
    .dt_r   (dt_r)
  );

  assign cyc_idle = idle;
  assign rdata    = rdata_q;

  // R2: the latch strobe never lasts two cycles
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R3: read and write strobes are mutually exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R3: transceiver enable only alongside a data strobe
  p_den_with_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !den_n |-> (!rd_n || !wr_n));

  // R7: space and direction hold once the address phase is over
  p_iom_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_idle && !ale) |-> ($stable(io_m) && $stable(dt_r)));

  // R11: no latch strobe right after a cycle ends
  p_no_start_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ale);

endmodule

// File: tb/busseq_unit_bench.sv
module busseq_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_io, req_word, ready_in;
  logic [15:0] req_seg, req_off, req_wdata, ad_in;
  logic [1:0]  req_segsel;
  logic        cyc_idle, ad_oe, bhe_n, ale, io_m, rd_n, wr_n, den_n, dt_r, done;
  logic [15:0] ad_out, rdata;
  logic [3:0]  as_out;

  int n_chk  = 0;
  int n_fail = 0;
  int n_cyc  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busseq_unit u_busseq_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .req_write(req_write), .req_io(req_io),
    .req_word(req_word), .req_segsel(req_segsel), .req_wdata(req_wdata),
    .ready_in(ready_in), .ad_in(ad_in), .cyc_idle(cyc_idle),
    .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .bhe_n(bhe_n),
    .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
    .dt_r(dt_r), .rdata(rdata), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc == WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", n_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic stray_req(input logic [15:0] salt);
    req_valid  = 1'b1;
    req_seg    = salt;
    req_off    = ~salt;
    req_wdata  = salt ^ 16'h5A5A;
    req_segsel = salt[1:0];
    req_write  = salt[2];
    req_io     = salt[3];
    req_word   = salt[4];
  endtask

  task automatic run_cyc(input logic [15:0] seg, input logic [15:0] off,
                         input logic wr, input logic io, input logic word,
                         input logic [1:0] ss, input logic [15:0] wd,
                         input int nw, input logic [15:0] rv);
    int   exp_addr;
    logic exp_bhe_n;
    exp_addr  = ((int'(seg) << 4) + int'(off)) & 32'hFFFFF;
    exp_bhe_n = !(word || exp_addr[0]);

    chk("R11 idle before request", 32'(cyc_idle), 1);
    req_valid = 1'b1; req_seg = seg; req_off = off; req_write = wr;
    req_io = io; req_word = word; req_segsel = ss; req_wdata = wd;
    ready_in = 1'b0;
    @(posedge clk); @(negedge clk);

    // T1
    stray_req(seg ^ 16'hA53C);
    chk("R2 ale in T1", 32'(ale), 1);
    chk("R1 low address", 32'(ad_out), exp_addr & 32'hFFFF);
    chk("R1 high address", 32'(as_out), (exp_addr >> 16) & 32'hF);
    chk("R8 oe in T1", 32'(ad_oe), 1);
    chk("R10 bhe_n in T1", 32'(bhe_n), 32'(exp_bhe_n));
    chk("R7 io_m T1", 32'(io_m), 32'(io));
    chk("R7 dt_r T1", 32'(dt_r), 32'(wr));
    chk("R3 strobes idle in T1", 32'({rd_n, wr_n, den_n}), 7);
    @(posedge clk); @(negedge clk);

    // T2
    chk("R2 ale low in T2", 32'(ale), 0);
    chk("R3 rd_n T2", 32'(rd_n), 32'(wr));
    chk("R3 wr_n T2", 32'(wr_n), 32'(!wr));
    chk("R3 den_n T2", 32'(den_n), 0);
    chk("R8 oe T2", 32'(ad_oe), 32'(wr));
    if (wr) chk("R8 write data T2", 32'(ad_out), 32'(wd));
    chk("R9 status T2", 32'(as_out), 32'(ss));
    chk("R9 S7 T2", 32'(bhe_n), 0);
    chk("R7 io_m T2", 32'(io_m), 32'(io));
    @(posedge clk); @(negedge clk);

    // T3
    chk("R11 status kept T3", 32'(as_out), 32'(ss));
    if (wr) chk("R11 write data kept T3", 32'(ad_out), 32'(wd));
    chk("R3 den_n T3", 32'(den_n), 0);
    chk("R7 dt_r T3", 32'(dt_r), 32'(wr));
    chk("R6 no done T3", 32'(done), 0);

    for (int w = 0; w <= nw; w++) begin
      ready_in = (w == nw);
      ad_in    = (w == nw) ? rv : ~rv;
      @(posedge clk); @(negedge clk);
      if (w < nw) begin
        chk("R4 wait state strobe", 32'(wr ? wr_n : rd_n), 0);
        chk("R4 no done in wait", 32'(done), 0);
        chk("R8 oe in wait", 32'(ad_oe), 32'(wr));
      end
    end
    ready_in = 1'b0;
    ad_in    = 16'h0000;

    // T4
    chk("R6 done in T4", 32'(done), 1);
    chk("R3 strobes released T4", 32'({rd_n, wr_n, den_n}), 7);
    chk("R7 io_m T4", 32'(io_m), 32'(io));
    chk("R8 oe T4", 32'(ad_oe), 32'(wr));
    chk("R9 status T4", 32'(as_out), 32'(ss));
    if (!wr) chk("R5 read data", 32'(rdata), 32'(rv));
    stray_req(seg ^ 16'h0F0F);
    @(posedge clk); @(negedge clk);

    // back to idle with a request pending that arrived in T4
    req_valid = 1'b0;
    chk("R6 idle after T4", 32'(cyc_idle), 1);
    chk("R6 done single cycle", 32'(done), 0);
    chk("R11 no cycle from stray request", 32'(ale), 0);
    chk("R12 strobes high idle", 32'({rd_n, wr_n, den_n}), 7);
  endtask

  logic [15:0] segs [6];
  logic [15:0] offs [6];

  initial begin
    segs[0] = 16'h3000; offs[0] = 16'h0123;
    segs[1] = 16'h6000; offs[1] = 16'hFFE0;
    segs[2] = 16'hFFFF; offs[2] = 16'hFFFF;
    segs[3] = 16'h0000; offs[3] = 16'h0000;
    segs[4] = 16'h1234; offs[4] = 16'h5677;
    segs[5] = 16'hF000; offs[5] = 16'h1000;

    rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_off = '0;
    req_write = 1'b0; req_io = 1'b0; req_word = 1'b0; req_segsel = '0;
    req_wdata = '0; ready_in = 1'b0; ad_in = '0;
    repeat (3) @(negedge clk);

    chk("R12 idle in reset", 32'(cyc_idle), 1);
    chk("R12 strobes in reset", 32'({rd_n, wr_n, den_n}), 7);
    chk("R12 ale/oe/done in reset", 32'({ale, ad_oe, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle after reset", 32'(cyc_idle), 1);

    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 8; m++)
        for (int nw = 0; nw < 3; nw++)
          run_cyc(segs[p], offs[p], m[0], m[1], m[2], 2'(p + m),
                  16'(16'hC0DE ^ (p * 97 + m * 13 + nw)), nw,
                  16'(16'h3A11 + p * 257 + m * 31 + nw));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule